// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves control transfers for a 32-bit in-order core. For each presented instruction it decides whether the transfer is taken and computes the next program counter. It also produces the value a linking form writes back, a flag that marks a delayed transfer, and requests to set or clear bits in the machine status register. The register itself lives elsewhere. Pipeline flush and the execution of the instruction in the delay slot are handled outside the unit.

Each instruction belongs to one of four kinds. An unconditional transfer always redirects. A conditional transfer tests one register against zero. A return transfer targets a register plus an immediate. The fourth kind is reserved and is never taken. Separate flags select an absolute or relative target, an immediate or register operand, linking, delay, and break behaviour. The result is registered and appears one clock after the request.

Top module: `brx_unit`

## Requirements
- R1: While rst_ni is low, every output is zero.
- R2: cond_i selects a signed test of test_i against zero: 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than, 5 greater or equal. Codes 6 and 7 are never satisfied. The test matters only when kind_i is 1 (conditional).
- R3: A taken relative transfer (kind_i 0 or 1, abs_i low) gives next_pc_o = pc_i + offset. The offset is imm_i when use_imm_i is high and rb_i otherwise, and the sum wraps at 32 bits.
- R4: A transfer that is not taken gives next_pc_o = pc_i + 4 with taken_o low. This covers a failed condition and kind_i 3.
- R5: kind_i 0 (unconditional) is always taken. When abs_i is high on kind 0 or 1, a taken transfer gives next_pc_o equal to the selected offset value itself.
- R6: link_we_o is high when link_i is high or a break is requested. link_data_o is pc_i.
- R7: delay_slot_o equals delay_i for every valid request, whether or not the transfer is taken.
- R8: brk_i with kind_i 0 is a break. It raises set_bip_o, forces a link, and is taken. brk_i on any other kind has no effect.
- R9: kind_i 2 (return) is always taken, with next_pc_o = test_i + imm_i. ret_kind_i 1 raises set_ie_o, ret_kind_i 2 raises clr_bip_o, and 0 or 3 requests nothing.
- R10: Outputs follow a request by one clock with valid_o high. One clock after a cycle with valid_i low, valid_o, taken_o, link_we_o, delay_slot_o and all status requests are low, and next_pc_o and link_data_o hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present |
| pc_i | input | 32 | Current program counter |
| test_i | input | 32 | Register tested against zero; base for returns |
| rb_i | input | 32 | Register offset or target |
| imm_i | input | 32 | Immediate offset, target or return displacement |
| use_imm_i | input | 1 | Select imm_i instead of rb_i for kinds 0 and 1 |
| cond_i | input | 3 | Condition code |
| kind_i | input | 2 | 0 unconditional, 1 conditional, 2 return, 3 reserved |
| abs_i | input | 1 | Absolute target for kinds 0 and 1 |
| link_i | input | 1 | Write pc_i to the destination register |
| delay_i | input | 1 | Delayed variant |
| brk_i | input | 1 | Break form (kind 0 only) |
| ret_kind_i | input | 2 | Return flavour: 1 interrupt return, 2 break return |
| valid_o | output | 1 | Result valid |
| next_pc_o | output | 32 | Next program counter |
| taken_o | output | 1 | Transfer redirects |
| link_we_o | output | 1 | Link write request |
| link_data_o | output | 32 | Link value |
| delay_slot_o | output | 1 | Delay slot follows |
| set_bip_o | output | 1 | Request to set break-in-progress |
| set_ie_o | output | 1 | Request to set interrupt enable |
| clr_bip_o | output | 1 | Request to clear break-in-progress |

## Verification
Several functions can land in the same cycle. A delayed flag can meet a failed condition, and a break always brings a link and a redirect with it. The sweep covers every pairing of kind, condition, target mode, link, delay, break and return flavour. It runs against register values at zero, at one, at minus one and at both signed extremes. Each output is judged separately against an arithmetic model, so a delay flag that drops on a not-taken branch, or a link lost under a break, shows up on its own check.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int XLEN       = 32;
  localparam int INSN_BYTES = 4;

  typedef enum logic [1:0] {
    K_UNC  = 2'd0,
    K_COND = 2'd1,
    K_RET  = 2'd2,
    K_NONE = 2'd3
  } br_kind_e;

  typedef enum logic [2:0] {
    C_EQ = 3'd0, C_NE = 3'd1, C_LT = 3'd2, C_LE = 3'd3,
    C_GT = 3'd4, C_GE = 3'd5, C_N6 = 3'd6, C_N7 = 3'd7
  } br_cond_e;

  typedef enum logic [1:0] {
    R_PLAIN = 2'd0,
    R_INTR  = 2'd1,
    R_BRK   = 2'd2,
    R_RSVD  = 2'd3
  } ret_kind_e;
endpackage

// File: rtl/brx_cond.sv
module brx_cond #(
  parameter int W = 32
) (
  input  logic [W-1:0] test_i,
  input  logic [2:0]   cond_i,
  output logic         hit_o
);
  logic is_zero, is_neg;
  assign is_zero = (test_i == '0);
  assign is_neg  = test_i[W-1];

  always_comb begin
    unique case (cond_i)
      3'd0:    hit_o = is_zero;
      3'd1:    hit_o = !is_zero;
      3'd2:    hit_o = is_neg;
      3'd3:    hit_o = is_neg || is_zero;
      3'd4:    hit_o = !is_neg && !is_zero;
      3'd5:    hit_o = !is_neg;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/brx_target.sv
module brx_target #(
  parameter int W     = 32,
  parameter int STEP  = 4
) (
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] test_i,
  input  logic [W-1:0] rb_i,
  input  logic [W-1:0] imm_i,
  input  logic         use_imm_i,
  input  logic         abs_i,
  input  logic         is_ret_i,
  input  logic         taken_i,
  output logic [W-1:0] next_pc_o
);
  localparam logic [W-1:0] STEP_V = W'(STEP);

  logic [W-1:0] opnd, jump_pc;
  assign opnd = use_imm_i ? imm_i : rb_i;

  always_comb begin
    if (is_ret_i)   jump_pc = test_i + imm_i;
    else if (abs_i) jump_pc = opnd;
    else            jump_pc = pc_i + opnd;
  end

  assign next_pc_o = taken_i ? jump_pc : pc_i + STEP_V;
endmodule

// File: rtl/brx_status.sv
module brx_status (
  input  logic [1:0] kind_i,
  input  logic       brk_i,
  input  logic [1:0] ret_kind_i,
  output logic       set_bip_o,
  output logic       set_ie_o,
  output logic       clr_bip_o
);
  import brx_pkg::*;
  assign set_bip_o = brk_i && (kind_i == K_UNC);
  assign set_ie_o  = (kind_i == K_RET) && (ret_kind_i == R_INTR);
  assign clr_bip_o = (kind_i == K_RET) && (ret_kind_i == R_BRK);
endmodule

// File: rtl/brx_unit.sv
module brx_unit
  import brx_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int STEP = INSN_BYTES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] test_i,
  input  logic [W-1:0] rb_i,
  input  logic [W-1:0] imm_i,
  input  logic         use_imm_i,
  input  logic [2:0]   cond_i,
  input  logic [1:0]   kind_i,
  input  logic         abs_i,
  input  logic         link_i,
  input  logic         delay_i,
  input  logic         brk_i,
  input  logic [1:0]   ret_kind_i,
  output logic         valid_o,
  output logic [W-1:0] next_pc_o,
  output logic         taken_o,
  output logic         link_we_o,
  output logic [W-1:0] link_data_o,
  output logic         delay_slot_o,
  output logic         set_bip_o,
  output logic         set_ie_o,
  output logic         clr_bip_o
);
  logic         hit, taken_d;
  logic [W-1:0] npc_d;
  logic         bip_d, ie_d, clrb_d;

  brx_cond #(.W(W)) u_cond (
    .test_i (test_i),
    .cond_i (cond_i),
    .hit_o  (hit)
  );

  assign taken_d = (kind_i == K_UNC) || (kind_i == K_RET) ||
                   ((kind_i == K_COND) && hit);

  brx_target #(.W(W), .STEP(STEP)) u_tgt (
    .pc_i      (pc_i),
    .test_i    (test_i),
    .rb_i      (rb_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .abs_i     (abs_i),
    .is_ret_i  (kind_i == K_RET),
    .taken_i   (taken_d),
    .next_pc_o (npc_d)
  );

  brx_status u_stat (
    .kind_i     (kind_i),
    .brk_i      (brk_i),
    .ret_kind_i (ret_kind_i),
    .set_bip_o  (bip_d),
    .set_ie_o   (ie_d),
    .clr_bip_o  (clrb_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      next_pc_o    <= '0;
      taken_o      <= 1'b0;
      link_we_o    <= 1'b0;
      link_data_o  <= '0;
      delay_slot_o <= 1'b0;
      set_bip_o    <= 1'b0;
      set_ie_o     <= 1'b0;
      clr_bip_o    <= 1'b0;
    end else begin
      valid_o      <= valid_i;
      taken_o      <= valid_i && taken_d;
      link_we_o    <= valid_i && (link_i || bip_d);
      delay_slot_o <= valid_i && delay_i;
      set_bip_o    <= valid_i && bip_d;
      set_ie_o     <= valid_i && ie_d;
      clr_bip_o    <= valid_i && clrb_d;
      if (valid_i) begin
        next_pc_o   <= npc_d;
        link_data_o <= pc_i;
      end
    end
  end
endmodule

// File: rtl/brx_unit_chk.sv
module brx_unit_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] pc_i,
  input logic [W-1:0] test_i,
  input logic [W-1:0] imm_i,
  input logic [2:0]   cond_i,
  input logic [1:0]   kind_i,
  input logic         link_i,
  input logic         delay_i,
  input logic [1:0]   ret_kind_i,
  input logic         valid_o,
  input logic [W-1:0] next_pc_o,
  input logic         taken_o,
  input logic         link_we_o,
  input logic [W-1:0] link_data_o,
  input logic         delay_slot_o,
  input logic         set_bip_o,
  input logic         set_ie_o,
  input logic         clr_bip_o
);
  p_never_cond_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind_i == 2'd1 && cond_i[2:1] == 2'b11 |=> !taken_o);

  p_not_taken_pc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind_i == 2'd3 |=> next_pc_o == $past(pc_i) + W'(4));

  p_link_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && link_i |=> link_we_o && link_data_o == $past(pc_i));

  p_delay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> delay_slot_o == $past(delay_i));

  p_break_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_bip_o |-> taken_o && link_we_o);

  p_ret_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind_i == 2'd2 |=> taken_o && next_pc_o == $past(test_i) + $past(imm_i));

  p_ret_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_ie_o && clr_bip_o));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !taken_o && !link_we_o && !delay_slot_o
                 && !set_bip_o && !set_ie_o && !clr_bip_o && $stable(next_pc_o));
endmodule

bind brx_unit brx_unit_chk #(.W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .pc_i         (pc_i),
  .test_i       (test_i),
  .imm_i        (imm_i),
  .cond_i       (cond_i),
  .kind_i       (kind_i),
  .link_i       (link_i),
  .delay_i      (delay_i),
  .ret_kind_i   (ret_kind_i),
  .valid_o      (valid_o),
  .next_pc_o    (next_pc_o),
  .taken_o      (taken_o),
  .link_we_o    (link_we_o),
  .link_data_o  (link_data_o),
  .delay_slot_o (delay_slot_o),
  .set_bip_o    (set_bip_o),
  .set_ie_o     (set_ie_o),
  .clr_bip_o    (clr_bip_o)
);

// File: tb/sim_brx_unit.sv
`timescale 1ns/1ps
module sim_brx_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] pc_i = '0, test_i = '0, rb_i = '0, imm_i = '0;
  logic        use_imm_i = 1'b0;
  logic [2:0]  cond_i = '0;
  logic [1:0]  kind_i = '0;
  logic        abs_i = 1'b0, link_i = 1'b0, delay_i = 1'b0, brk_i = 1'b0;
  logic [1:0]  ret_kind_i = '0;
  logic        valid_o, taken_o, link_we_o, delay_slot_o;
  logic        set_bip_o, set_ie_o, clr_bip_o;
  logic [31:0] next_pc_o, link_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  brx_unit u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit cond_ok(input logic [2:0] c, input logic [31:0] v);
    int signed s;
    s = v;
    case (c)
      3'd0: return s == 0;
      3'd1: return s != 0;
      3'd2: return s < 0;
      3'd3: return s <= 0;
      3'd4: return s > 0;
      3'd5: return s >= 0;
      default: return 1'b0;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] tv [5];
    logic [31:0] off, e_pc, last_pc;
    bit e_tk, e_lk;
    int n;
    tv[0] = 32'h0; tv[1] = 32'h1; tv[2] = 32'hFFFF_FFFF;
    tv[3] = 32'h7FFF_FFFF; tv[4] = 32'h8000_0000;
    n = 0;

    repeat (3) @(negedge clk_i);
    // R1: outputs cleared under reset
    chk("R1 valid", 32'(valid_o), 0);
    chk("R1 pc", next_pc_o, 0);
    chk("R1 flags", {24'd0, taken_o, link_we_o, delay_slot_o, set_bip_o, set_ie_o, clr_bip_o, 2'b0}, 0);
    chk("R1 link", link_data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int k = 0; k < 4; k++)
    for (int c = 0; c < 8; c++)
    for (int t = 0; t < 5; t++)
    for (int m = 0; m < 32; m++)
    for (int r = 0; r < 4; r++) begin
      valid_i    = 1'b1;
      kind_i     = 2'(k);
      cond_i     = 3'(c);
      test_i     = tv[t];
      abs_i      = m[0];
      use_imm_i  = m[1];
      link_i     = m[2];
      delay_i    = m[3];
      brk_i      = m[4];
      ret_kind_i = 2'(r);
      pc_i       = 32'hFFFF_FF00 + 32'(n * 4);
      rb_i       = 32'h0000_1000 + 32'(n * 8);
      imm_i      = 32'hFFFF_FFF0 - 32'(n * 12);
      n++;
      @(negedge clk_i);
      off  = use_imm_i ? imm_i : rb_i;
      e_tk = (k == 0) || (k == 2) || (k == 1 && cond_ok(cond_i, test_i));
      if (!e_tk)      e_pc = pc_i + 32'd4;
      else if (k == 2) e_pc = test_i + imm_i;
      else if (abs_i) e_pc = off;
      else            e_pc = pc_i + off;
      e_lk = link_i || (brk_i && k == 0);
      chk("R10 valid", 32'(valid_o), 1);
      if (k == 1) chk("R2 taken", 32'(taken_o), 32'(e_tk));
      else        chk("R5 taken", 32'(taken_o), 32'(e_tk));
      if (!e_tk)        chk("R4 next_pc", next_pc_o, e_pc);
      else if (k == 2)  chk("R9 next_pc", next_pc_o, e_pc);
      else if (abs_i)   chk("R5 next_pc", next_pc_o, e_pc);
      else              chk("R3 next_pc", next_pc_o, e_pc);
      chk("R6 link_we", 32'(link_we_o), 32'(e_lk));
      chk("R6 link_data", link_data_o, pc_i);
      chk("R7 delay", 32'(delay_slot_o), 32'(delay_i));
      chk("R8 set_bip", 32'(set_bip_o), 32'(brk_i && k == 0));
      chk("R9 set_ie", 32'(set_ie_o), 32'(k == 2 && r == 1));
      chk("R9 clr_bip", 32'(clr_bip_o), 32'(k == 2 && r == 2));
    end

    // R10: idle cycle clears flags and holds pc and link value
    last_pc = next_pc_o;
    valid_i = 1'b0; kind_i = 2'd0; link_i = 1'b1; delay_i = 1'b1; brk_i = 1'b1;
    pc_i = 32'h1234_5678;
    e_pc = link_data_o;
    @(negedge clk_i);
    chk("R10 valid", 32'(valid_o), 0);
    chk("R10 flags", {25'd0, taken_o, link_we_o, delay_slot_o, set_bip_o, set_ie_o, clr_bip_o, 1'b0}, 0);
    chk("R10 pc hold", next_pc_o, last_pc);
    chk("R10 link hold", link_data_o, e_pc);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule